// File: doc/BRIEF.md
# Paged Memory Relocation Unit

This block turns a 16-bit virtual address into a wider physical address for a small minicomputer memory management unit. The virtual space has eight pages of 8 KB each. A pair of page register banks, one for the privileged (kernel) mode and one for the unprivileged (user) mode, holds a base value for each page. The bank that is used follows the mode input directly, with no clock edge in between. An address that lands in the top 8 KB of physical space raises an I/O-page select output. This select is what peripheral decoders watch.

A single enable bit in a control word chooses between two behaviours. With the enable clear, the low seven pages pass straight through and the top virtual page is forced onto the I/O page. With the enable set, every page goes through its page register, the top page included. Software reads and writes the page registers and the control word through a word-wide register port. A processor bus-reset pulse clears the enable bit. This lets a machine that has lost its mapping recover.

Top module: `reloc_unit`

## Requirements
- R1: After `rst_n` is low, all sixteen page registers and the control word read as zero, and translation is disabled.
- R2: With translation disabled, a virtual address whose bits [15:13] are 0 to 6 produces a physical address equal to the virtual address with every bit above bit 15 cleared.
- R3: With translation disabled, a virtual address whose bits [15:13] are 7 produces a physical address whose bits above bit 15 are all one and whose low 16 bits equal the virtual address.
- R4: With translation enabled, the physical address is (page register << 6) + VA[12:0], truncated to the physical width. The page index is VA[15:13], and this holds for all eight pages, page 7 included.
- R5: Register addresses 0 to 7 are the kernel page registers (used when `user_mode` is 0). Addresses 8 to 15 are the user page registers (used when `user_mode` is 1). A change of `user_mode` changes the physical address in the same cycle, without a clock edge.
- R6: `io_sel` is 1 exactly when the physical address lies in the top 8 KB of the physical space, and 0 otherwise.
- R7: Register address 16 is the control word. Bit 0 is the translation enable. It reads back in bit 0, other bits read as zero, and writes to the other bits are ignored.
- R8: A `sys_reset` pulse clears the enable bit at the next clock edge and leaves the page registers unchanged. When it coincides with a control-word write, the clear wins.
- R9: Register reads are combinational from `reg_addr`. Addresses 17 to 31 read as zero, and writes to them change no register.
- R10: The physical width `PA_W` can be 16, 18 or 22. In the 16-bit build the disabled mode passes the address through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| sys_reset | input | 1 | Bus-reset pulse, clears the translation enable |
| user_mode | input | 1 | 0 selects the kernel bank, 1 the user bank |
| va | input | 16 | Virtual address |
| pa | output | PA_W | Physical address |
| io_sel | output | 1 | Physical address is in the top 8 KB |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
The bench builds two copies side by side, one with `PA_W` = 22 and one with `PA_W` = 18, and drives both with the same stimulus. The 22-bit copy reaches the full six-bit upper fill of the disabled top page. The 18-bit copy shows truncation of a large page base, where bits shifted above the physical width are dropped. The same copy shows the I/O-page boundary moving to the lower top of an 18-bit space.

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int PA_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_reset,
  input  logic            user_mode,
  input  logic [15:0]     va,
  output logic [PA_W-1:0] pa,
  output logic            io_sel,
  input  logic            reg_wr,
  input  logic [4:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata
);

  localparam logic [4:0]      CTRL_ADDR = 5'd16;
  localparam logic [PA_W-1:0] IO_BASE   = {PA_W{1'b1}} << 13;

  logic [15:0]     base_q [16];
  logic            reloc_on;
  logic [2:0]      page;
  logic [15:0]     sel_base;
  logic [PA_W-1:0] mapped;
  logic [PA_W-1:0] direct;

  // Page registers and the enable bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) base_q[i] <= '0;
      reloc_on <= 1'b0;
    end else begin
      if (reg_wr && !reg_addr[4]) base_q[reg_addr[3:0]] <= reg_wdata;
      if (sys_reset)
        reloc_on <= 1'b0;
      else if (reg_wr && reg_addr == CTRL_ADDR)
        reloc_on <= reg_wdata[0];
    end
  end

  assign page     = va[15:13];
  assign sel_base = base_q[{user_mode, page}];
  assign mapped   = PA_W'({sel_base, 6'b0}) + PA_W'(va[12:0]);

  generate
    if (PA_W > 16) begin : g_wide
      assign direct = {{(PA_W-16){page == 3'd7}}, va};
    end else begin : g_narrow
      assign direct = va;
    end
  endgenerate

  assign pa     = reloc_on ? mapped : direct;
  assign io_sel = &pa[PA_W-1:13];

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[4])
      reg_rdata = base_q[reg_addr[3:0]];
    else if (reg_addr == CTRL_ADDR)
      reg_rdata = {15'b0, reloc_on};
  end

  assert_low_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reloc_on && va[15:13] != 3'd7) |-> (pa == PA_W'(va)));

  assert_top_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reloc_on && va[15:13] == 3'd7) |-> (pa >= IO_BASE && pa[12:0] == va[12:0]));

  assert_io_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel == (pa >= IO_BASE));

  assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CTRL_ADDR && !sys_reset) |=> (reg_rdata[0] == $past(reg_wdata[0]) || reg_addr != CTRL_ADDR));

  assert_bus_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !reloc_on);

  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && sys_reset) |=> $stable(base_q[{user_mode, va[15:13]}]) || $changed(user_mode) || $changed(va[15:13]));

endmodule

// File: tb/reloc_unit_tb_top.sv
module reloc_unit_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic sys_reset = 0;
  logic user_mode = 0;
  logic [15:0] va = 0;
  logic reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [21:0] pa22;
  logic [17:0] pa18;
  logic io22, io18;
  logic [15:0] rd22, rd18;
  int runs = 0, fails = 0;
  logic [15:0] shadow [16];
  bit en_exp = 0;

  always #5 clk = ~clk;

  reloc_unit #(.PA_W(22)) dut_i (.clk(clk), .rst_n(rst_n), .sys_reset(sys_reset),
    .user_mode(user_mode), .va(va), .pa(pa22), .io_sel(io22), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd22));

  reloc_unit #(.PA_W(18)) dut18_i (.clk(clk), .rst_n(rst_n), .sys_reset(sys_reset),
    .user_mode(user_mode), .va(va), .pa(pa18), .io_sel(io18), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd18));

  function automatic logic [31:0] model_pa(int w, bit on, logic [15:0] base, logic [15:0] v);
    logic [31:0] s, m;
    m = (32'h1 << w) - 1;
    if (on) s = ({16'b0, base} << 6) + {19'b0, v[12:0]};
    else if (v[15:13] == 3'd7) s = 32'hFFFF_0000 | {16'b0, v};
    else s = {16'b0, v};
    return s & m;
  endfunction

  function automatic bit model_io(int w, logic [31:0] p);
    logic [31:0] m;
    m = (32'h1 << w) - 1;
    return p >= (m & ~32'h1FFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    if (!a[4]) shadow[a[3:0]] = d;
  endtask

  task automatic rd_check(string req, logic [4:0] a, logic [15:0] exp);
    @(negedge clk);
    reg_addr = a; #1;
    check(req, {16'b0, rd22}, {16'b0, exp});
    check(req, {16'b0, rd18}, {16'b0, exp});
  endtask

  task automatic xlate_check(string req, bit um, logic [15:0] v);
    logic [15:0] b;
    logic [31:0] e22, e18;
    @(negedge clk);
    user_mode = um; va = v; #1;
    b = shadow[{um, v[15:13]}];
    e22 = model_pa(22, en_exp, b, v);
    e18 = model_pa(18, en_exp, b, v);
    check(req, {10'b0, pa22}, e22);
    check({req, "/R10"}, {14'b0, pa18}, e18);
    check({req, "/R6"}, {31'b0, io22}, {31'b0, model_io(22, e22)});
    check({req, "/R6"}, {31'b0, io18}, {31'b0, model_io(18, e18)});
  endtask

  task automatic t_reset_R1;
    rd_check("R1", 5'd0, 16'h0);
    rd_check("R1", 5'd9, 16'h0);
    rd_check("R1", 5'd16, 16'h0);
    xlate_check("R1", 0, 16'h1234);
  endtask

  task automatic t_off_low_R2;
    xlate_check("R2", 0, 16'h0000);
    xlate_check("R2", 1, 16'hDFFF);
    xlate_check("R2", 0, 16'h4ABC);
  endtask

  task automatic t_off_top_R3;
    xlate_check("R3", 0, 16'hE000);
    xlate_check("R3", 1, 16'hFFFE);
    check("R3", {10'b0, pa22}, 32'h3FFFFE);
    check("R3/R10", {14'b0, pa18}, 32'h3FFFE);
  endtask

  task automatic t_on_map_R4;
    for (int i = 0; i < 7; i++) wr(5'(i), 16'(i * 16'h0200 + 16'h0011));
    wr(5'd6, 16'hFF80);
    wr(5'd7, 16'h0000);
    wr(5'd16, 16'h0001); en_exp = 1;
    for (int i = 0; i < 8; i++) xlate_check("R4", 0, 16'(i * 16'h2000 + 16'h0123));
    xlate_check("R4", 0, 16'hFFFF);
    check("R4", {10'b0, pa22}, 32'h001FFF);
    check("R4/R6", {31'b0, io22}, 32'h0);
    xlate_check("R4", 0, 16'hC010);
    check("R4/R6", {31'b0, io22}, 32'h1);
  endtask

  task automatic t_modes_R5;
    for (int i = 8; i < 16; i++) wr(5'(i), 16'(16'h1000 + i * 16'h0040));
    xlate_check("R5", 0, 16'h2456);
    xlate_check("R5", 1, 16'h2456);
    @(negedge clk); user_mode = 0; #1;
    check("R5", {10'b0, pa22}, model_pa(22, 1, shadow[1], 16'h2456));
    rd_check("R5", 5'd13, shadow[13]);
  endtask

  task automatic t_ctrl_R7;
    wr(5'd16, 16'hFFFE); en_exp = 0;
    rd_check("R7", 5'd16, 16'h0000);
    xlate_check("R7", 0, 16'hE100);
    wr(5'd16, 16'hFFFF); en_exp = 1;
    rd_check("R7", 5'd16, 16'h0001);
    xlate_check("R7", 0, 16'hE100);
  endtask

  task automatic t_sysreset_R8;
    @(negedge clk); sys_reset = 1;
    @(posedge clk); #1; sys_reset = 0; en_exp = 0;
    rd_check("R8", 5'd16, 16'h0000);
    rd_check("R8", 5'd6, 16'hFF80);
    xlate_check("R8", 0, 16'hC010);
    @(negedge clk);
    sys_reset = 1; reg_wr = 1; reg_addr = 5'd16; reg_wdata = 16'h0001;
    @(posedge clk); #1; sys_reset = 0; reg_wr = 0;
    rd_check("R8", 5'd16, 16'h0000);
  endtask

  task automatic t_unmapped_R9;
    wr(5'd16, 16'h0001); en_exp = 1;
    wr(5'd20, 16'hFFFF);
    wr(5'd31, 16'h0000);
    rd_check("R9", 5'd20, 16'h0000);
    rd_check("R9", 5'd16, 16'h0001);
    rd_check("R9", 5'd4, shadow[4]);
    xlate_check("R9", 0, 16'h8222);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset_R1;
    t_off_low_R2;
    t_off_top_R3;
    t_on_map_R4;
    t_modes_R5;
    t_ctrl_R7;
    t_sysreset_R8;
    t_unmapped_R9;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule